// File: doc/BRIEF.md
# Watchdog Timer with Keyed Feed Sequence

This block is a bus-mapped watchdog. Software sets an enable bit, programs a reload constant, and then keeps the system alive by writing a fixed two-word key to a feed register. Each correct key loads a down-counter from the constant. A divide-by-four prescaler then steps the counter down. If the counter runs out, or if a feed sequence that has started is completed with any value other than the expected second word, the watchdog expires.

On expiry the block raises a timeout flag and a sticky interrupt flag, and it drives the interrupt output. It can also drive a fixed-length system reset pulse. Once the enable bit is set, software cannot clear it. The only way back to the disabled state is the block's own reset input.

Software reaches the block through a single-cycle write and read strobe pair with a byte address. Read data appears on the cycle after the read strobe.

Top module: `wdog_feed`

## Requirements
- R1: After reset, the control word reads 0, the reload constant reads 0xFF, the counter reads 0, and both `irq_o` and `sys_rst_o` are low.
- R2: The registers are at word offsets 0x0 (control), 0x4 (reload constant), 0x8 (feed, write-only, reads 0) and 0xC (live counter, read-only). `rd_data` holds the selected value from the cycle after `rd_en`, and a read changes no state.
- R3: Control bit 0 is the enable. Writing 1 sets it. Writing 0 has no effect once it is set.
- R4: A value below 0xFF written to the reload constant is stored as 0xFF. Any other value is stored as written.
- R5: After enable, the counter stays at 0 and does not expire until the first valid feed.
- R6: A feed write of 0xAA followed directly by a feed write of 0x55 loads the counter with the constant. The counter then drops by one every 4 clock cycles. A later valid feed reloads it again.
- R7: With no further feed, expiry follows exactly 4×(constant+1) cycles after the 0x55 write. On expiry, control bit 2 (timeout) and control bit 3 (interrupt) are set, and counting stops.
- R8: Writing 1 to control bit 2 clears the timeout flag. Control bit 3 cannot be cleared by software. `irq_o` follows control bit 3.
- R9: If a feed write follows a 0xAA feed write and carries any value other than 0x55, the watchdog expires on that write.
- R10: A read or write of any other register between the 0xAA and the 0x55 cancels the sequence. The 0x55 then neither reloads the counter nor expires it.
- R11: If control bit 1 (reset enable) is set at expiry, `sys_rst_o` goes high for exactly 16 cycles. If bit 1 is clear, `sys_rst_o` stays low.
- R12: While the watchdog is disabled, feed writes neither load the counter nor cause an expiry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Watchdog and bus clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| wr_en | input | 1 | Write strobe, one cycle per access |
| rd_en | input | 1 | Read strobe, one cycle per access |
| addr | input | 4 | Byte address of the register |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data, valid the cycle after `rd_en` |
| irq_o | output | 1 | Interrupt level, equal to the sticky interrupt flag |
| sys_rst_o | output | 1 | System reset request pulse |

## Verification
The hardest case to reach is the exact cycle of expiry. It depends on a prescaler phase that is invisible at the ports and on a counter that may be read part way through. The bench fixes the phase by timing everything from the 0x55 write, and it picks random constants and random read points from a fixed seed. It then predicts both the counter value it reads and the cycle on which the interrupt rises. The cancelled-sequence case is also hard to observe, because a cancelled 0x55 looks like a no-op. The bench checks it by reading the counter afterwards and confirming that the value matches continued counting rather than a fresh load.

// File: rtl/wdog_feed.sv
module wdog_feed #(
  parameter int CW      = 32,
  parameter int PRE_DIV = 4,
  parameter int RST_CYC = 16,
  parameter int MIN_TC  = 255
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [3:0]  addr,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data,
  output logic        irq_o,
  output logic        sys_rst_o
);
  localparam int PW = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;
  localparam int RW = $clog2(RST_CYC + 1);
  localparam logic [1:0] SEL_CTL = 2'd0, SEL_TC = 2'd1, SEL_FEED = 2'd2, SEL_CNT = 2'd3;
  localparam logic [31:0] KEY_A = 32'h0000_00AA, KEY_B = 32'h0000_0055;

  logic en_q, rst_en_q, tof_q, intf_q, run_q, armed_q;
  logic [CW-1:0] tc_q, cnt_q;
  logic [PW-1:0] pre_q;
  logic [RW-1:0] rst_cnt_q;
  logic [31:0]   rd_q;

  wire       aligned   = (addr[1:0] == 2'b00);
  wire [1:0] sel       = addr[3:2];
  wire       wr_ok     = wr_en && aligned;
  wire       rd_ok     = rd_en && aligned;
  wire       ctl_wr    = wr_ok && sel == SEL_CTL;
  wire       tc_wr     = wr_ok && sel == SEL_TC;
  wire       feed_wr   = wr_ok && sel == SEL_FEED;
  wire       other_acc = (wr_ok || rd_ok) && sel != SEL_FEED;
  wire       good_feed = en_q && armed_q && feed_wr && wr_data == KEY_B;
  wire       bad_feed  = en_q && armed_q && feed_wr && wr_data != KEY_B;
  wire       tick      = run_q && pre_q == PW'(PRE_DIV - 1);
  wire       cnt_exp   = tick && cnt_q == '0;
  wire       expire    = bad_feed || cnt_exp;

  assign irq_o     = intf_q;
  assign sys_rst_o = rst_cnt_q != '0;
  assign rd_data   = rd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0; rst_en_q <= 1'b0; tof_q <= 1'b0; intf_q <= 1'b0;
    end else begin
      if (ctl_wr) begin
        en_q     <= en_q | wr_data[0];
        rst_en_q <= wr_data[1];
      end
      if (expire) begin
        tof_q  <= 1'b1;
        intf_q <= 1'b1;
      end else if (ctl_wr && wr_data[2]) begin
        tof_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tc_q <= CW'(MIN_TC);
    else if (tc_wr) tc_q <= (wr_data[CW-1:0] < CW'(MIN_TC)) ? CW'(MIN_TC) : wr_data[CW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else if (!en_q || other_acc) armed_q <= 1'b0;
    else if (feed_wr) armed_q <= !armed_q && wr_data == KEY_A;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0; pre_q <= '0; run_q <= 1'b0;
    end else if (good_feed) begin
      cnt_q <= tc_q; pre_q <= '0; run_q <= 1'b1;
    end else if (expire) begin
      pre_q <= '0; run_q <= 1'b0;
    end else if (tick) begin
      cnt_q <= cnt_q - 1'b1; pre_q <= '0;
    end else if (run_q) begin
      pre_q <= pre_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_cnt_q <= '0;
    else if (expire && rst_en_q) rst_cnt_q <= RW'(RST_CYC);
    else if (rst_cnt_q != '0) rst_cnt_q <= rst_cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_q <= '0;
    else if (rd_ok) begin
      case (sel)
        SEL_CTL: rd_q <= {28'd0, intf_q, tof_q, rst_en_q, en_q};
        SEL_TC:  rd_q <= 32'(tc_q);
        SEL_CNT: rd_q <= 32'(cnt_q);
        default: rd_q <= '0;
      endcase
    end
  end

  // R3
  en_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n) en_q |=> en_q);
  // R8
  intf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n) intf_q |=> intf_q);
  // R4
  tc_floor_chk: assert property (@(posedge clk) disable iff (!rst_n) tc_q >= CW'(MIN_TC));
  // R6
  cnt_down_chk: assert property (@(posedge clk) disable iff (!rst_n) !good_feed |=> cnt_q <= $past(cnt_q));
  // R11
  rst_gate_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(sys_rst_o) |-> $past(rst_en_q) && $past(expire));
  // R12
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n) !en_q |-> !run_q && !intf_q);
endmodule

// File: tb/wdog_feed_tb_top.sv
`timescale 1ns/1ps
module wdog_feed_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0] addr = '0;
  logic [31:0] wr_data = '0, rd_data;
  logic irq_o, sys_rst_o;
  int total = 0, bad = 0;

  wdog_feed dut_i (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
                   .wr_data(wr_data), .rd_data(rd_data), .irq_o(irq_o), .sys_rst_o(sys_rst_o));

  always #2.5 clk = ~clk;

  function automatic int clamp(int v); return (v < 255) ? 255 : v; endfunction
  function automatic int cnt_at(int c, int w); return c - w / 4; endfunction

  task automatic chk(string req, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; wr_en = 0; rd_en = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0; d = rd_data;
  endtask

  task automatic feed(); wr(4'h8, 32'hAA); wr(4'h8, 32'h55); endtask

  task automatic pulse_len(output int n);
    n = 0;
    while (sys_rst_o && n < 100) begin n++; @(negedge clk); end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog timeout");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int n, c, w;
    bit seen;
    void'($urandom(32'd2024));
    @(negedge clk);
    do_reset();
    // R1 / R2 reset state and map
    chk("R1 irq", irq_o, 0); chk("R1 sys_rst", sys_rst_o, 0);
    rd(4'h0, d); chk("R1 ctl", d, 0);
    rd(4'h4, d); chk("R1 tc", d, 32'hFF);
    rd(4'hC, d); chk("R1 cnt", d, 0);
    rd(4'h8, d); chk("R2 feed reads 0", d, 0);
    // R4 clamp
    wr(4'h4, 32'h10); rd(4'h4, d); chk("R4 clamp", d, 32'hFF);
    wr(4'h4, 32'h1234); rd(4'h4, d); chk("R4 keep", d, 32'h1234);
    wr(4'h4, 32'h100); rd(4'h4, d); chk("R4 keep2", d, 32'h100);
    // R12 disabled feeds
    feed(); rd(4'hC, d); chk("R12 no load", d, 0);
    wr(4'h8, 32'hAA); wr(4'h8, 32'h13); @(negedge clk);
    chk("R12 no expire", irq_o, 0); rd(4'h0, d); chk("R12 ctl", d, 0);
    // R5 enable arms only
    wr(4'h0, 32'h1); repeat (1500) @(negedge clk);
    chk("R5 irq idle", irq_o, 0); rd(4'hC, d); chk("R5 cnt idle", d, 0);
    // R3 sticky enable
    wr(4'h0, 32'h0); rd(4'h0, d); chk("R3 sticky", d[0], 1);
    // R7 timing, rst disabled
    wr(4'h4, 32'hFF); feed();
    n = 0; seen = 0;
    while (!irq_o && n < 5000) begin @(negedge clk); n++; if (sys_rst_o) seen = 1; end
    chk("R7 period", n, 1024); chk("R11 no pulse", seen | sys_rst_o, 0);
    rd(4'h0, d); chk("R7 flags", d, 32'h9 | 32'h4);
    // R8 flag clear
    wr(4'h0, 32'h5); rd(4'h0, d); chk("R8 tof cleared", d, 32'h9);
    chk("R8 irq held", irq_o, 1);
    // R6 refeed restarts
    do_reset(); wr(4'h0, 32'h1); wr(4'h4, 32'hFF); feed();
    repeat (600) @(negedge clk);
    feed(); n = 0;
    while (!irq_o && n < 5000) begin @(negedge clk); n++; end
    chk("R6 refeed period", n, 1024);
    // R6 / R7 / R11 random
    for (int i = 0; i < 6; i++) begin
      bit re;
      do_reset();
      re = $urandom_range(0, 1);
      wr(4'h0, re ? 32'h3 : 32'h1);
      c = $urandom_range(0, 600);
      wr(4'h4, c); c = clamp(c);
      feed();
      w = $urandom_range(0, 4 * c);
      repeat (w) @(negedge clk);
      rd(4'hC, d); chk("R6 live count", d, cnt_at(c, w));
      n = w + 1;
      while (!irq_o && n < 10000) begin @(negedge clk); n++; end
      chk("R7 random period", n, 4 * (c + 1));
      pulse_len(n); chk("R11 pulse len", n, re ? 16 : 0);
    end
    // R9 wrong key
    do_reset(); wr(4'h0, 32'h3); wr(4'h4, 32'h200); feed();
    repeat (10) @(negedge clk);
    wr(4'h8, 32'hAA); wr(4'h8, 32'h77);
    chk("R9 immediate", irq_o, 1);
    pulse_len(n); chk("R9 R11 pulse", n, 16);
    // R10 cancel
    do_reset(); wr(4'h0, 32'h1); wr(4'h4, 32'h100); feed();
    repeat (20) @(negedge clk);
    wr(4'h8, 32'hAA); rd(4'h0, d); wr(4'h8, 32'h55);
    chk("R10 no expire", irq_o, 0);
    rd(4'hC, d); chk("R10 no reload", d, 32'h100 - 5);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule